// File: doc/BRIEF.md
# Sampling Tap Window Selector

After a tuning sweep, software or a sequencer loads a pass/fail bitmap into this block. The bitmap has one bit for each probed sampling-tap position and covers two full turns of the tap range, so a passing window that wraps past the last tap still shows up as one unbroken run. On a start pulse the block walks the bitmap one bit per clock and tracks the longest unbroken run of passes. It then takes the middle of that run, folds the index back into the tap range, and stores the result in the tap output register.

A run that is too short ends the selection with an error, and the stored tap is left as it was. A successful selection arms the automatic re-tuning enable. The block also holds a sticky re-tune error flag. A hardware event sets the flag. A query reports the flag only while re-tuning is armed, and the report clears it.

Top module: `tap_window_select`

## Requirements
- R1: After reset, `tapSet` is 0 and `autoRetuneEn`, `retuneErrFlag`, `done`, `selOk`, `selErr` and `errHit` are all 0.
- R2: A `start` pulse taken while idle produces a one-cycle `done` exactly 2*TAP_COUNT+2 clock cycles after the edge that samples it. `done` comes with exactly one of `selOk` or `selErr`. A `start` that arrives while a selection is running is ignored.
- R3: Bitmap bit i (bit 0 = position 0) is 1 for a pass. The winning run is the longest run of consecutive 1s. A later run replaces the current best only if it is strictly longer, so on a tie the earliest run wins.
- R4: A run that is still open at the last position (bit 2*TAP_COUNT-1) is judged the same way as a run that ends at a 0.
- R5: If the winning run covers positions s to e, the new `tapSet` is ((s+e)/2) mod TAP_COUNT, with integer division.
- R6: If the winning run is shorter than MIN_RUN (default 3), `selErr` is raised, `tapSet` keeps its previous value and `autoRetuneEn` stays 0.
- R7: An accepted `start` clears `retuneErrFlag` and `autoRetuneEn` before the scan. A successful selection sets `autoRetuneEn` in the same cycle that `selOk` is raised.
- R8: A cycle with `retuneErrIn` high sets `retuneErrFlag`. The flag then stays set until it is cleared.
- R9: A cycle with `errQuery` high gives `errHit`=1 in the next cycle if, and only if, both `autoRetuneEn` and `retuneErrFlag` were 1. In that case the flag is cleared in the same cycle. Otherwise the flag is unchanged. When a clear and a set fall in the same cycle, the clear wins.
- R10: A bitmap write (`mapWrEn`) is taken only while idle. A write during a selection does not change the bitmap in use, nor the bitmap kept for later selections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mapWrEn | input | 1 | Load the pass/fail bitmap (idle only) |
| mapWrData | input | 2*TAP_COUNT | Pass/fail bitmap, bit i = position i |
| start | input | 1 | Begin a selection |
| retuneErrIn | input | 1 | Re-tune error event from the sampling logic |
| errQuery | input | 1 | Ask for the re-tune error and clear it if reported |
| done | output | 1 | One-cycle end-of-selection pulse |
| selOk | output | 1 | Selection succeeded (with done) |
| selErr | output | 1 | Selection failed, run too short (with done) |
| tapSet | output | $clog2(TAP_COUNT) | Chosen sampling tap |
| autoRetuneEn | output | 1 | Automatic re-tuning armed |
| retuneErrFlag | output | 1 | Sticky re-tune error flag |
| errHit | output | 1 | Query result: error reported and cleared |

## Verification
The assertions assume that `start` and `mapWrEn` never fall in the same idle cycle, since that case has no defined priority. They also assume that `retuneErrIn` does not share a cycle with a clearing query when the bench checks the flag. The stimulus applies each control as a single-cycle pulse at the falling edge, keeps bitmap writes apart from starts, and issues error events and queries only while no selection is running. The random bitmaps are drawn at several pass densities, so both short and wrapping runs occur.

// File: rtl/tapsel_pkg.sv
package tapsel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_SCAN = 2'd2,
    ST_FIN  = 2'd3
  } selState_t;

  typedef struct packed {
    logic prep;
    logic step;
    logic finish;
  } ctlStrobe_t;

endpackage

// File: rtl/tapsel_ctrl.sv
module tapsel_ctrl
  import tapsel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lastBit,
  input  logic       runOk,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       selOk,
  output logic       selErr
);

  selState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) stateNext = ST_PREP;
      ST_PREP: stateNext = ST_SCAN;
      ST_SCAN: if (lastBit) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.prep   = (state == ST_PREP);
    strobe.step   = (state == ST_SCAN);
    strobe.finish = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      selOk  <= 1'b0;
      selErr <= 1'b0;
    end else begin
      state  <= stateNext;
      done   <= strobe.finish;
      selOk  <= strobe.finish && runOk;
      selErr <= strobe.finish && !runOk;
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $onehot({selOk, selErr}));

  p_idle_after_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/tapsel_dpath.sv
module tapsel_dpath
  import tapsel_pkg::*;
#(
  parameter int TAP_COUNT = 8,
  parameter int MIN_RUN   = 3,
  localparam int MAPW = 2 * TAP_COUNT,
  localparam int IW   = $clog2(MAPW + 1),
  localparam int BW   = (MAPW > 1) ? $clog2(MAPW) : 1,
  localparam int TW   = (TAP_COUNT > 1) ? $clog2(TAP_COUNT) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strobe,
  input  logic            busy,
  input  logic            mapWrEn,
  input  logic [MAPW-1:0] mapWrData,
  output logic            lastBit,
  output logic            runOk,
  output logic [TW-1:0]   tapSet
);

  logic [MAPW-1:0] bitmap;
  logic [IW-1:0]   idx, runLen, bestLen, bestStart, bestEnd;
  logic            curBit, runBeatsBest;
  logic [IW-1:0]   finLen, finStart, finEnd, mid;
  logic [IW:0]     sum;
  logic [TW-1:0]   tapCalc;

  assign curBit       = bitmap[idx[BW-1:0]];
  assign lastBit      = (idx == IW'(MAPW - 1));
  assign runBeatsBest = (runLen > bestLen);

  // Resolve the run still open when the scan ends (idx == MAPW here)
  always_comb begin
    if (runBeatsBest) begin
      finLen   = runLen;
      finStart = idx - runLen;
      finEnd   = idx - IW'(1);
    end else begin
      finLen   = bestLen;
      finStart = bestStart;
      finEnd   = bestEnd;
    end
    sum     = {1'b0, finStart} + {1'b0, finEnd};
    mid     = IW'(sum >> 1);
    tapCalc = TW'(mid % IW'(TAP_COUNT));
  end

  assign runOk = (finLen >= IW'(MIN_RUN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitmap <= '0;
    end else if (mapWrEn && !busy) begin
      bitmap <= mapWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx       <= '0;
      runLen    <= '0;
      bestLen   <= '0;
      bestStart <= '0;
      bestEnd   <= '0;
    end else if (strobe.prep) begin
      idx       <= '0;
      runLen    <= '0;
      bestLen   <= '0;
      bestStart <= '0;
      bestEnd   <= '0;
    end else if (strobe.step) begin
      idx <= idx + IW'(1);
      if (curBit) begin
        runLen <= runLen + IW'(1);
      end else begin
        if (runBeatsBest) begin
          bestLen   <= runLen;
          bestStart <= idx - runLen;
          bestEnd   <= idx - IW'(1);
        end
        runLen <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapSet <= '0;
    end else if (strobe.finish && runOk) begin
      tapSet <= tapCalc;
    end
  end

  p_run_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= idx);

  p_best_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    bestLen <= IW'(MAPW));

  p_map_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && mapWrEn) |=> $stable(bitmap));

endmodule

// File: rtl/tapsel_status.sv
module tapsel_status
  import tapsel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       runOk,
  input  logic       retuneErrIn,
  input  logic       errQuery,
  output logic       autoRetuneEn,
  output logic       retuneErrFlag,
  output logic       errHit
);

  logic reportNow;

  assign reportNow = errQuery && autoRetuneEn && retuneErrFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoRetuneEn  <= 1'b0;
      retuneErrFlag <= 1'b0;
      errHit        <= 1'b0;
    end else begin
      if (strobe.prep)                     autoRetuneEn <= 1'b0;
      else if (strobe.finish && runOk)     autoRetuneEn <= 1'b1;

      if (strobe.prep || reportNow)        retuneErrFlag <= 1'b0;
      else if (retuneErrIn)                retuneErrFlag <= 1'b1;

      errHit <= reportNow;
    end
  end

  p_hit_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    errHit |-> !retuneErrFlag);

  p_hit_needs_en_r9: assert property (@(posedge clk) disable iff (!rstN)
    errHit |-> $past(autoRetuneEn));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retuneErrFlag && !errQuery && !strobe.prep) |=> retuneErrFlag);

endmodule

// File: rtl/tap_window_select.sv
module tap_window_select
  import tapsel_pkg::*;
#(
  parameter int TAP_COUNT = 8,
  parameter int MIN_RUN   = 3,
  localparam int MAPW = 2 * TAP_COUNT,
  localparam int TW   = (TAP_COUNT > 1) ? $clog2(TAP_COUNT) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            mapWrEn,
  input  logic [MAPW-1:0] mapWrData,
  input  logic            start,
  input  logic            retuneErrIn,
  input  logic            errQuery,
  output logic            done,
  output logic            selOk,
  output logic            selErr,
  output logic [TW-1:0]   tapSet,
  output logic            autoRetuneEn,
  output logic            retuneErrFlag,
  output logic            errHit
);

  ctlStrobe_t strobe;
  logic busy, lastBit, runOk;

  tapsel_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .lastBit(lastBit), .runOk(runOk),
    .strobe(strobe), .busy(busy), .done(done), .selOk(selOk), .selErr(selErr)
  );

  tapsel_dpath #(.TAP_COUNT(TAP_COUNT), .MIN_RUN(MIN_RUN)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy), .mapWrEn(mapWrEn),
    .mapWrData(mapWrData), .lastBit(lastBit), .runOk(runOk), .tapSet(tapSet)
  );

  tapsel_status uStatus (
    .clk(clk), .rstN(rstN), .strobe(strobe), .runOk(runOk),
    .retuneErrIn(retuneErrIn), .errQuery(errQuery),
    .autoRetuneEn(autoRetuneEn), .retuneErrFlag(retuneErrFlag), .errHit(errHit)
  );

  p_ok_arms_r7: assert property (@(posedge clk) disable iff (!rstN)
    selOk |-> autoRetuneEn);

  p_tap_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !selOk |-> $stable(tapSet));

  p_err_unarmed_r6: assert property (@(posedge clk) disable iff (!rstN)
    selErr |-> !autoRetuneEn);

endmodule

// File: tb/tb_tap_window_select.sv
module tb_tap_window_select;
  localparam int N    = 8;
  localparam int MAPW = 2 * N;
  localparam int TW   = $clog2(N);
  localparam int LAT  = 2 * N + 3; // falling edges from start drive to done visible

  logic clk = 0, rstN = 0;
  logic mapWrEn = 0, start = 0, retuneErrIn = 0, errQuery = 0;
  logic [MAPW-1:0] mapWrData = '0;
  logic done, selOk, selErr, autoRetuneEn, retuneErrFlag, errHit;
  logic [TW-1:0] tapSet;

  int errors = 0, checks = 0, cycles = 0;
  int expTap = 0;

  tap_window_select #(.TAP_COUNT(N), .MIN_RUN(3)) dut (
    .clk(clk), .rstN(rstN), .mapWrEn(mapWrEn), .mapWrData(mapWrData),
    .start(start), .retuneErrIn(retuneErrIn), .errQuery(errQuery),
    .done(done), .selOk(selOk), .selErr(selErr), .tapSet(tapSet),
    .autoRetuneEn(autoRetuneEn), .retuneErrFlag(retuneErrFlag), .errHit(errHit)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void refSel(input logic [MAPW-1:0] m, output bit ok, output int tap);
    int run = 0, best = 0, bs = 0, be = 0;
    for (int i = 0; i < MAPW; i++) begin
      if (m[i]) run++;
      else begin
        if (run > best) begin best = run; bs = i - run; be = i - 1; end
        run = 0;
      end
    end
    if (run > best) begin best = run; bs = MAPW - run; be = MAPW - 1; end
    ok  = (best >= 3);
    tap = ((bs + be) / 2) % N;
  endfunction

  task automatic loadMap(input logic [MAPW-1:0] m);
    @(negedge clk); mapWrEn = 1; mapWrData = m;
    @(negedge clk); mapWrEn = 0;
  endtask

  // Runs a selection on the loaded map refMap; optional busy write / restart
  task automatic runSel(input logic [MAPW-1:0] refMap, input string tag,
                        input bit busyPoke);
    bit ok; int tap; int cnt = 0;
    refSel(refMap, ok, tap);
    @(negedge clk); start = 1;
    while (cnt < 60) begin
      @(negedge clk); cnt++;
      start = 0;
      mapWrEn = 0;
      if (cnt == 2) begin
        chk(autoRetuneEn == 0 && retuneErrFlag == 0, "R7 cleared at start",
            {autoRetuneEn, retuneErrFlag}, 0);
      end
      if (busyPoke && cnt == 5) begin
        mapWrEn = 1; mapWrData = ~refMap; start = 1; // R10 / R2 ignored while busy
      end
      if (done) break;
    end
    mapWrEn = 0; start = 0;
    chk(cnt == LAT, {tag, " R2 latency"}, cnt, LAT);
    chk(selOk == ok && selErr == !ok, {tag, " R6 ok/err"}, {selOk, selErr}, {ok, !ok});
    if (ok) expTap = tap;
    chk(int'(tapSet) == expTap, {tag, " R5 tap"}, tapSet, expTap);
    chk(autoRetuneEn == ok, {tag, " R7 autoRetuneEn"}, autoRetuneEn, ok);
    @(negedge clk);
    chk(!done, {tag, " R2 single done"}, done, 0);
  endtask

  task automatic pulseErr();
    @(negedge clk); retuneErrIn = 1;
    @(negedge clk); retuneErrIn = 0;
  endtask

  task automatic query(output bit hit);
    @(negedge clk); errQuery = 1;
    @(negedge clk); errQuery = 0; hit = errHit;
  endtask

  initial begin
    logic [MAPW-1:0] m;
    bit hit;
    void'($urandom(32'd20240611));
    #1;
    chk(tapSet == 0 && !done && !selOk && !selErr && !autoRetuneEn && !retuneErrFlag && !errHit,
        "R1 reset", tapSet, 0);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(tapSet == 0 && !autoRetuneEn && !retuneErrFlag && !errHit && !done,
        "R1 after release", tapSet, 0);

    m = 16'hFFFF; loadMap(m); runSel(m, "R3 all pass", 0);
    m = 16'h0000; loadMap(m); runSel(m, "R6 all fail", 0);
    m = 16'h00E7; loadMap(m); runSel(m, "R3 tie earliest", 0);
    m = 16'hFC0B; loadMap(m); runSel(m, "R4 trailing run", 0);
    m = 16'h01C0; loadMap(m); runSel(m, "R6 run of three", 0);
    m = 16'h1B36; loadMap(m); runSel(m, "R6 runs of two", 0);
    m = 16'h0FF0; loadMap(m); runSel(m, "R5 wrap centre", 0);

    m = 16'h3E00; loadMap(m); runSel(m, "R10 busy write", 1);
    runSel(m, "R10 map kept", 0);

    // R8/R9 with re-tuning armed
    m = 16'h00F0; loadMap(m); runSel(m, "R7 arm", 0);
    pulseErr();
    chk(retuneErrFlag == 1, "R8 flag set", retuneErrFlag, 1);
    repeat (4) @(negedge clk);
    chk(retuneErrFlag == 1, "R8 flag sticky", retuneErrFlag, 1);
    query(hit);
    chk(hit == 1, "R9 reported", hit, 1);
    chk(retuneErrFlag == 0, "R9 cleared by report", retuneErrFlag, 0);
    query(hit);
    chk(hit == 0, "R9 no flag no report", hit, 0);

    // R9 with re-tuning not armed
    m = 16'h0003; loadMap(m); runSel(m, "R6 disarm", 0);
    pulseErr();
    query(hit);
    chk(hit == 0, "R9 unarmed no report", hit, 0);
    chk(retuneErrFlag == 1, "R9 unarmed flag kept", retuneErrFlag, 1);
    m = 16'h0070; loadMap(m); runSel(m, "R7 start clears flag", 0);
    chk(retuneErrFlag == 0, "R7 flag after selection", retuneErrFlag, 0);

    // Random maps at several pass densities
    for (int k = 0; k < 40; k++) begin
      int dens = k % 4;
      m = '0;
      for (int b = 0; b < MAPW; b++) begin
        int r = $urandom_range(0, 7);
        m[b] = (r < 2 + 2 * dens);
      end
      loadMap(m);
      runSel(m, "R3 random", (k % 7) == 3);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule